// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block watches the stream of retired program-counter values and the data-bus accesses of a processor core and compares them against programmable breakpoint resources. There are four program-counter comparators, one address-range comparator and one data-value comparator. When a match occurs, the block raises a one-cycle trigger pulse. Core halt logic can use that pulse to stop the core, and trace logic can use it to start or stop recording.

There are two trigger modes. In one-level mode, any enabled comparator that matches fires the trigger. In two-level mode, the comparators are split by a selection mask. A level-1 match arms the unit, and a later level-2 match while armed fires the trigger. In this mode the arming event opens trace capture and the final trigger closes it. A sticky status register records which comparators caused each trigger until software clears them.

Software programs the unit through a simple write port (`cfg_we`, `cfg_sel`, `cfg_wdata`). The select codes are:
- 0 to 3: program-counter reference values 0 to 3.
- 4: range lower bound.
- 5: range upper bound.
- 6: data reference value.
- 7: data byte-ignore mask.
- 8: control word.
- 9: status clear.

Top module: `bkpt_trigger`

## Requirements
- R1: PC comparator i (i = 0..3) matches when `pc_vld` is high, `pc_val` equals reference i, and control bit i is set. Its status bit is bit i.
- R2: The range comparator (enable: control bit 4, status bit 4) matches on `bus_vld` when lower ≤ `bus_addr` ≤ upper, with both bounds included.
- R3: Control bit 6 inverts the range test, so the comparator matches only on addresses outside [lower, upper].
- R4: The data comparator (enable: control bit 5, status bit 5) matches on `bus_vld` when the range test (after any inversion) holds and every data byte j whose mask bit j is 0 equals byte j of the reference. A mask bit of 1 ignores that byte.
- R5: Control bits [8:7] select the data access type. 01 accepts reads only (`bus_wr`=0), 10 accepts writes only, and 00 or 11 accepts either.
- R6: A comparator whose enable bit is 0 never matches, never triggers and never sets status.
- R7: One-level mode (control bit 9 = 0): any match pulses `trig`. On that trigger, control bit 16 = 0 also pulses `trace_start`, and control bit 16 = 1 pulses `trace_stop` instead.
- R8: Two-level mode (control bit 9 = 1): control bits [15:10] mark the level-1 comparators, and all others are level-2.
  - A level-1 match while not armed sets `armed` and pulses `trace_start`.
  - A level-2 match while armed pulses `trig` and `trace_stop` and clears `armed`.
  - A level-2 match in the same cycle as the arming match does not fire.
- R9: A control-word write (select 8) clears `armed` and blocks arming in that cycle.
- R10: `hit_status` bits stick until cleared. Writing select 9 clears each bit whose data bit is 1, but a bit set by a trigger in the same cycle stays set. In two-level mode only the level-2 comparators that hit are recorded.
- R11: After reset, all outputs and all configuration registers are zero.
- R12: `trig`, `trace_start`, `trace_stop`, `armed` and `hit_status` change one clock after the strobe or write that causes them. Comparisons in the cycle of a configuration write use the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_vld | input | 1 | Retired PC value valid |
| pc_val | input | W | Retired program counter |
| bus_vld | input | 1 | Bus access valid |
| bus_addr | input | W | Bus access address |
| bus_data | input | W | Bus access data |
| bus_wr | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | W | Configuration write data |
| trig | output | 1 | One-cycle trigger pulse |
| trace_start | output | 1 | Trace capture start pulse |
| trace_stop | output | 1 | Trace capture stop pulse |
| armed | output | 1 | Two-level sequence armed |
| hit_status | output | 6 | Sticky comparator cause flags |

## Verification
Every result is due exactly one clock after the strobe or write that causes it. A configuration write first changes comparisons in the following cycle. The bench applies each input set at a falling edge and samples all outputs at the next falling edge. Its model advances exactly one step per cycle, using the configuration that held before any write in that cycle. Directed boundary cases (range bounds, same-cycle arming, same-cycle clear-and-set) read the outputs at that same falling edge.

// File: rtl/bkpt_trigger.sv
module bkpt_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pc_vld,
  input  logic [W-1:0] pc_val,
  input  logic         bus_vld,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_data,
  input  logic         bus_wr,
  input  logic         cfg_we,
  input  logic [3:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  output logic         trig,
  output logic         trace_start,
  output logic         trace_stop,
  output logic         armed,
  output logic [5:0]   hit_status
);
  localparam int NPC = 4;
  localparam int NC  = NPC + 2;
  localparam int NB  = W / 8;

  logic [W-1:0]  pc_ref [NPC];
  logic [W-1:0]  rng_lo, rng_hi, dref;
  logic [NB-1:0] bmask;
  logic [16:0]   ctrl;
  logic [NC-1:0] hit;
  logic [W-1:0]  dkeep;

  wire ctl_wr = cfg_we && (cfg_sel == 4'd8);
  wire clr_wr = cfg_we && (cfg_sel == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPC; i++) pc_ref[i] <= '0;
      rng_lo <= '0;
      rng_hi <= '0;
      dref   <= '0;
      bmask  <= '0;
      ctrl   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        4'd0, 4'd1, 4'd2, 4'd3: pc_ref[cfg_sel[1:0]] <= cfg_wdata;
        4'd4: rng_lo <= cfg_wdata;
        4'd5: rng_hi <= cfg_wdata;
        4'd6: dref   <= cfg_wdata;
        4'd7: bmask  <= cfg_wdata[NB-1:0];
        4'd8: ctrl   <= cfg_wdata[16:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NPC; i++) begin : g_pc
    assign hit[i] = ctrl[i] & pc_vld & (pc_val == pc_ref[i]);
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dkeep[b*8 +: 8] = {8{~bmask[b]}};
  end

  wire in_rng = (bus_addr >= rng_lo) && (bus_addr <= rng_hi);
  wire rng_q  = bus_vld & (in_rng ^ ctrl[6]);
  wire rw_ok  = (ctrl[8:7] == 2'b01) ? !bus_wr :
                (ctrl[8:7] == 2'b10) ?  bus_wr : 1'b1;

  assign hit[NPC]   = ctrl[4] & rng_q;
  assign hit[NPC+1] = ctrl[5] & rng_q & rw_ok & (((bus_data ^ dref) & dkeep) == '0);

  wire           two    = ctrl[9];
  wire [NC-1:0]  l1m    = ctrl[15:10];
  wire [NC-1:0]  l2hits = hit & ~l1m;
  wire           l1     = |(hit & l1m);
  wire           fire   = two ? (armed & (|l2hits)) : (|hit);
  wire           arm_ev = two & !armed & l1 & !ctl_wr;
  wire [NC-1:0]  cause  = two ? l2hits : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig        <= 1'b0;
      trace_start <= 1'b0;
      trace_stop  <= 1'b0;
      armed       <= 1'b0;
      hit_status  <= '0;
    end else begin
      trig        <= fire;
      trace_start <= two ? arm_ev : (fire & !ctrl[16]);
      trace_stop  <= two ? fire   : (fire &  ctrl[16]);
      if (ctl_wr || fire) armed <= 1'b0;
      else if (arm_ev)    armed <= 1'b1;
      hit_status  <= (hit_status & ~(clr_wr ? cfg_wdata[NC-1:0] : '0)) | (fire ? cause : '0);
    end
  end

  assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[5:0]) == 6'd0) |-> !trig);
  assert_trig_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(pc_vld || bus_vld));
  assert_two_lvl_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(ctrl[9])) |-> $past(armed));
  assert_armed_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ctrl[9]);
  assert_trace_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trace_start && trace_stop));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_wr) |-> ((hit_status & $past(hit_status)) == $past(hit_status)));
  assert_ctl_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr) |-> !armed);
endmodule

// File: tb/sim_bkpt_trigger.sv
module sim_bkpt_trigger;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_vld, bus_vld, bus_wr, cfg_we;
  logic [31:0] pc_val, bus_addr, bus_data, cfg_wdata;
  logic [3:0] cfg_sel;
  logic trig, trace_start, trace_stop, armed;
  logic [5:0] hit_status;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_pc [4];
  logic [31:0] m_lo, m_hi, m_dv;
  logic [3:0]  m_bm;
  logic [16:0] m_ctrl;
  logic        m_armed, e_trig, e_ts, e_tp;
  logic [5:0]  m_st;

  always #5 clk = ~clk;

  bkpt_trigger #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pc_vld(pc_vld), .pc_val(pc_val),
    .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_data(bus_data), .bus_wr(bus_wr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig(trig), .trace_start(trace_start), .trace_stop(trace_stop),
    .armed(armed), .hit_status(hit_status));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic pv, input logic [31:0] pcv, input logic bv,
                     input logic [31:0] a, input logic [31:0] d, input logic wr,
                     input logic we, input logic [3:0] sel, input logic [31:0] wd);
    logic [5:0] h, l2h;
    logic inr, rq, eqd, rwok, two, l1, fire, arm, ctlw, clrw;
    for (int i = 0; i < 4; i++) h[i] = m_ctrl[i] & pv & (pcv == m_pc[i]);
    inr = (a >= m_lo) && (a <= m_hi);
    rq  = bv & (inr ^ m_ctrl[6]);
    h[4] = m_ctrl[4] & rq;
    eqd = 1'b1;
    for (int b = 0; b < 4; b++) if (!m_bm[b] && d[b*8 +: 8] != m_dv[b*8 +: 8]) eqd = 1'b0;
    case (m_ctrl[8:7])
      2'b01: rwok = !wr;
      2'b10: rwok = wr;
      default: rwok = 1'b1;
    endcase
    h[5] = m_ctrl[5] & rq & rwok & eqd;
    two  = m_ctrl[9];
    l1   = |(h & m_ctrl[15:10]);
    l2h  = h & ~m_ctrl[15:10];
    ctlw = we && sel == 4'd8;
    clrw = we && sel == 4'd9;
    fire = two ? (m_armed && |l2h) : |h;
    arm  = two && !m_armed && l1 && !ctlw;
    e_trig = fire;
    e_ts = two ? arm  : (fire && !m_ctrl[16]);
    e_tp = two ? fire : (fire &&  m_ctrl[16]);
    m_st = (m_st & ~(clrw ? wd[5:0] : 6'd0)) | (fire ? (two ? l2h : h) : 6'd0);
    if (ctlw || fire) m_armed = 1'b0;
    else if (arm) m_armed = 1'b1;
    if (we) begin
      if (sel < 4) m_pc[sel[1:0]] = wd;
      else if (sel == 4) m_lo = wd;
      else if (sel == 5) m_hi = wd;
      else if (sel == 6) m_dv = wd;
      else if (sel == 7) m_bm = wd[3:0];
      else if (sel == 8) m_ctrl = wd[16:0];
    end
    pc_vld = pv; pc_val = pcv; bus_vld = bv; bus_addr = a; bus_data = d; bus_wr = wr;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    chk("R12 trig", {31'd0, trig}, {31'd0, e_trig});
    chk("R7 trace_start", {31'd0, trace_start}, {31'd0, e_ts});
    chk("R8 trace_stop", {31'd0, trace_stop}, {31'd0, e_tp});
    chk("R9 armed", {31'd0, armed}, {31'd0, m_armed});
    chk("R10 status", {26'd0, hit_status}, {26'd0, m_st});
  endtask

  task automatic wcfg(input logic [3:0] s, input logic [31:0] v);
    cyc(0, 0, 0, 0, 0, 0, 1, s, v);
  endtask
  task automatic pcs(input logic [31:0] v);
    cyc(1, v, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic wr);
    cyc(0, 0, 1, a, d, wr, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_pc[i] = 0;
    m_lo = 0; m_hi = 0; m_dv = 0; m_bm = 0; m_ctrl = 0; m_armed = 0; m_st = 0;
    e_trig = 0; e_ts = 0; e_tp = 0;
    pc_vld = 0; pc_val = 0; bus_vld = 0; bus_addr = 0; bus_data = 0; bus_wr = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset trig", {31'd0, trig}, 0);
    chk("R11 reset trace", {30'd0, trace_start, trace_stop}, 0);
    chk("R11 reset armed", {31'd0, armed}, 0);
    chk("R11 reset status", {26'd0, hit_status}, 0);
    pcs(32'h0);
    chk("R11 zero config no trigger", {31'd0, trig}, 0);

    wcfg(0, 32'h100); wcfg(8, 32'h1);
    pcs(32'h100);
    chk("R1 pc match trig", {31'd0, trig}, 1);
    chk("R1 pc status bit0", {26'd0, hit_status}, 6'h01);
    pcs(32'h104);
    chk("R1 pc mismatch", {31'd0, trig}, 0);
    cyc(1, 32'h100, 0, 0, 0, 0, 1, 4'd8, 32'h2);
    chk("R12 old config in write cycle", {31'd0, trig}, 1);
    pcs(32'h100);
    chk("R12 new config after write", {31'd0, trig}, 0);

    wcfg(9, 32'h3f); wcfg(4, 32'h1000); wcfg(5, 32'h1fff); wcfg(8, 32'h10);
    bus(32'h1000, 0, 0); chk("R2 low bound inclusive", {31'd0, trig}, 1);
    chk("R2 range status bit4", {26'd0, hit_status}, 6'h10);
    bus(32'h1fff, 0, 1); chk("R2 high bound inclusive", {31'd0, trig}, 1);
    bus(32'h2000, 0, 0); chk("R2 above range", {31'd0, trig}, 0);
    bus(32'h0fff, 0, 0); chk("R2 below range", {31'd0, trig}, 0);
    wcfg(8, 32'h50);
    bus(32'h2000, 0, 0); chk("R3 inverted outside", {31'd0, trig}, 1);
    bus(32'h1800, 0, 0); chk("R3 inverted inside", {31'd0, trig}, 0);

    wcfg(9, 32'h3f); wcfg(6, 32'haabbccdd); wcfg(8, 32'h20);
    bus(32'h1800, 32'haabbccdd, 0); chk("R4 data match", {31'd0, trig}, 1);
    chk("R4 data status bit5", {26'd0, hit_status}, 6'h20);
    bus(32'h1800, 32'haabbcc00, 0); chk("R4 byte differs", {31'd0, trig}, 0);
    wcfg(7, 32'h1);
    bus(32'h1800, 32'haabbcc00, 0); chk("R4 masked byte ignored", {31'd0, trig}, 1);
    bus(32'h2000, 32'haabbccdd, 0); chk("R4 range qualifies", {31'd0, trig}, 0);
    wcfg(8, 32'hA0);
    bus(32'h1800, 32'haabbccdd, 1); chk("R5 read-only rejects write", {31'd0, trig}, 0);
    bus(32'h1800, 32'haabbccdd, 0); chk("R5 read-only accepts read", {31'd0, trig}, 1);
    wcfg(8, 32'h120);
    bus(32'h1800, 32'haabbccdd, 0); chk("R5 write-only rejects read", {31'd0, trig}, 0);
    bus(32'h1800, 32'haabbccdd, 1); chk("R5 write-only accepts write", {31'd0, trig}, 1);

    wcfg(9, 32'h3f); wcfg(8, 32'h0);
    cyc(1, 32'h100, 1, 32'h1800, 32'haabbccdd, 0, 0, 0, 0);
    chk("R6 disabled no trig", {31'd0, trig}, 0);
    chk("R6 disabled no status", {26'd0, hit_status}, 0);
    wcfg(8, 32'h10001);
    pcs(32'h100);
    chk("R7 stop action", {30'd0, trace_start, trace_stop}, 2'b01);

    wcfg(9, 32'h3f); wcfg(1, 32'h200); wcfg(8, 32'h603);
    pcs(32'h200); chk("R8 level2 unarmed", {30'd0, trig, armed}, 2'b00);
    pcs(32'h100); chk("R8 arm", {30'd0, armed, trace_start}, 2'b11);
    pcs(32'h200); chk("R8 fire", {29'd0, trig, trace_stop, armed}, 3'b110);
    chk("R8 level2 status", {26'd0, hit_status}, 6'h02);
    wcfg(8, 32'h611);
    cyc(1, 32'h100, 1, 32'h1800, 0, 0, 0, 0, 0);
    chk("R8 same-cycle arms only", {30'd0, trig, armed}, 2'b01);
    wcfg(8, 32'h611);
    chk("R9 control write disarms", {31'd0, armed}, 0);
    cyc(1, 32'h100, 0, 0, 0, 0, 1, 4'd8, 32'h611);
    chk("R9 write blocks arming", {31'd0, armed}, 0);

    wcfg(8, 32'h1);
    cyc(1, 32'h100, 0, 0, 0, 0, 1, 4'd9, 32'h01);
    chk("R10 set wins over clear", {26'd0, hit_status}, 6'h03);
    wcfg(9, 32'h02);
    chk("R10 partial clear", {26'd0, hit_status}, 6'h01);

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r, wd;
      logic [3:0] s;
      r = $urandom;
      s = 4'($urandom % 10);
      case (s)
        0, 1, 2, 3: wd = $urandom % 16;
        4, 5:       wd = $urandom % 64;
        6:          wd = $urandom;
        8:          wd = {15'd0, 17'($urandom)};
        default:    wd = $urandom;
      endcase
      cyc(r[0], (r[1] ? m_pc[r[3:2]] : 32'($urandom % 16)),
          r[4], 32'($urandom % 64), (r[5] ? m_dv ^ {24'd0, r[15:8]} : m_dv ^ (32'(r[23:16]) << 8)),
          r[6], (r[9:7] == 3'd0), s, wd);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule